// File: doc/BRIEF.md
# Serial Receiver with Overrun Detection and External Character Sync

This block is the receive half of a programmable serial controller. It takes a serial line and a receive clock from off-chip, brings both into the system clock domain, and assembles characters of five to eight bits. Each completed character is placed in a one-deep holding buffer and receive-ready is raised. The CPU reads the character, and it can read a status word at any moment. The status word gives the buffer flags and the present levels of the line and the sync pin.

There are two framing modes. In asynchronous mode the receive clock runs at 16 or 64 times the bit rate. A falling line is checked again half a bit later. If that check passes, data bits are taken at mid-bit, followed by one stop bit. In synchronous mode each rising edge of the receive clock carries one bit. Assembly begins once the external sync pin goes high, and characters then follow back to back with no start or stop bits.

A character that completes while the previous one is still unread replaces it and sets an overrun flag. The overrun flag stays set until an error-clear strobe arrives. A low stop bit sets a framing flag, which stays set in the same way.

The controller is `usart_rx_fsm`. Its states and transitions are:

- **ST_OFF**: entered from any state when `rx_en` is low. It moves to ST_SYNC_WAIT or ST_HUNT according to `sync_mode`.
- **ST_HUNT**: moves to ST_START on a receive-clock tick that finds the line low.
- **ST_START**: after half a bit, moves to ST_DATA if the line is still low. It returns to ST_HUNT if the line is high.
- **ST_DATA**: after the last data bit, moves to ST_STOP.
- **ST_STOP**: samples the stop bit, delivers the character and returns to ST_HUNT.
- **ST_SYNC_WAIT**: moves to ST_SYNC_DATA when the synchronized `ext_sync` is high.
- **ST_SYNC_DATA**: delivers a character every N ticks. It stays in this state until `rx_en` falls.

Top module: `usart_rx`

## Requirements
- R1: After reset, `rx_ready` is 0, status bits [2:0] (ready, overrun, framing) are 0 and `rx_data` is 0.
- R2: In asynchronous mode with `fac_sel`=0 (16 receive clocks per bit), a frame made of one low start bit, N data bits sent LSB first and a high stop bit loads the data into `rx_data` and sets `rx_ready`.
- R3: With `fac_sel`=1 (64 receive clocks per bit), asynchronous frames are received in the same way.
- R4: The character length is 5 + `len_sel` bits. Bits above the character length read as 0 in `rx_data`.
- R5: A low pulse on the idle line that is shorter than half a bit does not start a character, and the receiver still accepts the next valid frame.
- R6: A stop bit sampled low sets the framing flag (status bit 2) while still delivering the data. The flag stays set through later good characters until `err_clr` is pulsed.
- R7: A `rd_strobe` pulse clears `rx_ready` and leaves the overrun flag unchanged.
- R8: A character completing while `rx_ready` is 1 replaces `rx_data` and sets the overrun flag (status bit 1). The flag is cleared only by `err_clr`.
- R9: With `sync_mode`=1, no character is assembled before `ext_sync` is seen high. After that, every rising receive-clock edge samples one bit, LSB first, and characters follow back to back with no start or stop bits.
- R10: While `rx_en` is 0, no character is assembled and `rx_ready` stays 0.
- R11: Status bit 3 shows the synchronized `rxd` level and status bit 4 shows the synchronized `ext_sync` level, whether or not the receiver is enabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rxc | input | 1 | Receive clock from off-chip, sampled on its rising edge |
| rxd | input | 1 | Serial receive line, idle high |
| ext_sync | input | 1 | External sync pin: a high level starts assembly in synchronous mode |
| sync_mode | input | 1 | 1 = synchronous, 0 = asynchronous |
| fac_sel | input | 1 | Asynchronous clock factor: 0 = x16, 1 = x64 |
| len_sel | input | 2 | Character length minus five |
| rx_en | input | 1 | Receive enable |
| rd_strobe | input | 1 | One-cycle pulse: CPU reads the data register |
| err_clr | input | 1 | One-cycle pulse: clear the overrun and framing flags |
| rx_data | output | 8 | Received character, zero-extended |
| rx_ready | output | 1 | Unread character present |
| status | output | 5 | {ext_sync level, rxd level, framing, overrun, ready} |

## Verification
The assertions assume the following about the inputs:

- `sync_mode`, `fac_sel` and `len_sel` change only while `rx_en` is low.
- The receive clock is slow enough that each of its phases spans several system clocks.

Under these assumptions every delivered character comes from the current mode, and the bit index never passes the selected length. The stimulus follows them by changing the configuration only inside a disable window. It runs the receive clock at 4 or 16 system clocks per period and changes `rxd` and `ext_sync` only on system clock falling edges, at a fixed phase of the receive clock.

// File: rtl/usart_rx_pkg.sv
package usart_rx_pkg;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_HUNT,
        ST_START,
        ST_DATA,
        ST_STOP,
        ST_SYNC_WAIT,
        ST_SYNC_DATA
    } rx_state_t;

    localparam int STAT_W = 5;

endpackage

// File: rtl/usart_rx_sync.sv
module usart_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rxc,
    input  logic rxd,
    input  logic ext_sync,
    output logic rxd_s,
    output logic ext_s,
    output logic tick
);
    localparam int NPIN = 3;
    // Bit order {ext_sync, rxd, rxc}; the line idles high.
    localparam logic [NPIN-1:0] RST_VAL = 3'b010;

    logic [NPIN-1:0] pins_in;
    logic [NPIN-1:0] pins_s;
    logic            rxc_d;

    assign pins_in = {ext_sync, rxd, rxc};

    for (genvar i = 0; i < NPIN; i++) begin : g_pin
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= {STAGES{RST_VAL[i]}};
            else        chain <= {chain[STAGES-2:0], pins_in[i]};
        end
        assign pins_s[i] = chain[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rxc_d <= 1'b0;
        else        rxc_d <= pins_s[0];
    end

    assign tick  = pins_s[0] & ~rxc_d;
    assign rxd_s = pins_s[1];
    assign ext_s = pins_s[2];

endmodule

// File: rtl/usart_rx_fsm.sv
module usart_rx_fsm
    import usart_rx_pkg::*;
#(
    parameter int DW     = 8,
    parameter int LEN_W  = 2,
    parameter int FAC_LO = 16,
    parameter int FAC_HI = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             rxd_s,
    input  logic             ext_s,
    input  logic             rx_en,
    input  logic             sync_mode,
    input  logic             fac_sel,
    input  logic [LEN_W-1:0] len_sel,
    output logic             char_valid,
    output logic [DW-1:0]    char_data,
    output logic             char_fe
);
    localparam int LEN_SPAN = (2 ** LEN_W) - 1;
    localparam int MIN_LEN  = DW - LEN_SPAN;
    localparam int CW       = $clog2(FAC_HI);
    localparam int IW       = $clog2(DW);

    rx_state_t       state, nxt;
    logic [CW-1:0]   cnt, lim_full, lim_half;
    logic [IW-1:0]   bit_idx, last_idx;
    logic [DW-1:0]   shreg, nsh;
    logic            at_full, at_half, idx_last;

    function automatic logic [DW-1:0] align_char(logic [DW-1:0] v, logic [LEN_W-1:0] ls);
        return v >> (LEN_SPAN - int'(ls));
    endfunction

    assign lim_full = fac_sel ? CW'(FAC_HI - 1) : CW'(FAC_LO - 1);
    assign lim_half = fac_sel ? CW'(FAC_HI / 2 - 1) : CW'(FAC_LO / 2 - 1);
    assign last_idx = IW'(MIN_LEN - 1) + IW'(len_sel);
    assign at_full  = (cnt == lim_full);
    assign at_half  = (cnt == lim_half);
    assign idx_last = (bit_idx == last_idx);
    assign nsh      = {rxd_s, shreg[DW-1:1]};

    // Next-state logic
    always_comb begin
        nxt = state;
        if (!rx_en) begin
            nxt = ST_OFF;
        end else begin
            unique case (state)
                ST_OFF:       nxt = sync_mode ? ST_SYNC_WAIT : ST_HUNT;
                ST_HUNT:      if (tick && !rxd_s) nxt = ST_START;
                ST_START:     if (tick && at_half) nxt = rxd_s ? ST_HUNT : ST_DATA;
                ST_DATA:      if (tick && at_full && idx_last) nxt = ST_STOP;
                ST_STOP:      if (tick && at_full) nxt = ST_HUNT;
                ST_SYNC_WAIT: if (ext_s) nxt = ST_SYNC_DATA;
                ST_SYNC_DATA: nxt = ST_SYNC_DATA;
                default:      nxt = ST_OFF;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= nxt;
    end

    // Outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt        <= '0;
            bit_idx    <= '0;
            shreg      <= '0;
            char_valid <= 1'b0;
            char_data  <= '0;
            char_fe    <= 1'b0;
        end else begin
            char_valid <= 1'b0;
            if (!rx_en) begin
                cnt     <= '0;
                bit_idx <= '0;
            end else begin
                unique case (state)
                    ST_OFF, ST_HUNT, ST_SYNC_WAIT: begin
                        cnt     <= '0;
                        bit_idx <= '0;
                    end
                    ST_START: begin
                        if (tick) cnt <= at_half ? '0 : cnt + 1'b1;
                    end
                    ST_DATA: begin
                        if (tick) begin
                            if (at_full) begin
                                cnt     <= '0;
                                shreg   <= nsh;
                                bit_idx <= idx_last ? '0 : bit_idx + 1'b1;
                            end else begin
                                cnt <= cnt + 1'b1;
                            end
                        end
                    end
                    ST_STOP: begin
                        if (tick) begin
                            if (at_full) begin
                                cnt        <= '0;
                                char_valid <= 1'b1;
                                char_data  <= align_char(shreg, len_sel);
                                char_fe    <= ~rxd_s;
                            end else begin
                                cnt <= cnt + 1'b1;
                            end
                        end
                    end
                    ST_SYNC_DATA: begin
                        if (tick) begin
                            shreg <= nsh;
                            if (idx_last) begin
                                bit_idx    <= '0;
                                char_valid <= 1'b1;
                                char_data  <= align_char(nsh, len_sel);
                                char_fe    <= 1'b0;
                            end else begin
                                bit_idx <= bit_idx + 1'b1;
                            end
                        end
                    end
                    default: begin
                        cnt     <= '0;
                        bit_idx <= '0;
                    end
                endcase
            end
        end
    end

    // R10: nothing is delivered in the cycle after the enable is low
    assert_no_char_disabled_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> !char_valid);

    // R9: synchronous characters never carry a framing error
    assert_sync_no_framing_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (char_valid && sync_mode) |-> !char_fe);

    // R4: the bit index stays inside the selected length
    assert_idx_in_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
        bit_idx <= last_idx);

endmodule

// File: rtl/usart_rx_buf.sv
module usart_rx_buf #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          char_valid,
    input  logic [DW-1:0] char_data,
    input  logic          char_fe,
    input  logic          rd_strobe,
    input  logic          err_clr,
    output logic [DW-1:0] data_q,
    output logic          ready_q,
    output logic          ovr_q,
    output logic          fe_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q  <= '0;
            ready_q <= 1'b0;
            ovr_q   <= 1'b0;
            fe_q    <= 1'b0;
        end else begin
            if (char_valid) data_q <= char_data;

            if (char_valid)     ready_q <= 1'b1;
            else if (rd_strobe) ready_q <= 1'b0;

            if (char_valid && ready_q) ovr_q <= 1'b1;
            else if (err_clr)          ovr_q <= 1'b0;

            if (char_valid && char_fe) fe_q <= 1'b1;
            else if (err_clr)          fe_q <= 1'b0;
        end
    end

    assert_load_sets_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
        char_valid |=> ready_q);

    assert_rd_clears_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && !char_valid) |=> !ready_q);

    assert_overwrite_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (char_valid && ready_q) |=> ovr_q);

    assert_overrun_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_q && !err_clr) |=> ovr_q);

    assert_framing_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (fe_q && !err_clr) |=> fe_q);

endmodule

// File: rtl/usart_rx.sv
module usart_rx
    import usart_rx_pkg::*;
#(
    parameter int DW          = 8,
    parameter int LEN_W       = 2,
    parameter int FAC_LO      = 16,
    parameter int FAC_HI      = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rxc,
    input  logic              rxd,
    input  logic              ext_sync,
    input  logic              sync_mode,
    input  logic              fac_sel,
    input  logic [LEN_W-1:0]  len_sel,
    input  logic              rx_en,
    input  logic              rd_strobe,
    input  logic              err_clr,
    output logic [DW-1:0]     rx_data,
    output logic              rx_ready,
    output logic [STAT_W-1:0] status
);
    logic          rxd_s, ext_s, tick;
    logic          char_valid, char_fe;
    logic [DW-1:0] char_data;
    logic          ovr_q, fe_q;

    usart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .rxc      (rxc),
        .rxd      (rxd),
        .ext_sync (ext_sync),
        .rxd_s    (rxd_s),
        .ext_s    (ext_s),
        .tick     (tick)
    );

    usart_rx_fsm #(
        .DW     (DW),
        .LEN_W  (LEN_W),
        .FAC_LO (FAC_LO),
        .FAC_HI (FAC_HI)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .rxd_s      (rxd_s),
        .ext_s      (ext_s),
        .rx_en      (rx_en),
        .sync_mode  (sync_mode),
        .fac_sel    (fac_sel),
        .len_sel    (len_sel),
        .char_valid (char_valid),
        .char_data  (char_data),
        .char_fe    (char_fe)
    );

    usart_rx_buf #(.DW(DW)) u_buf (
        .clk        (clk),
        .rst_n      (rst_n),
        .char_valid (char_valid),
        .char_data  (char_data),
        .char_fe    (char_fe),
        .rd_strobe  (rd_strobe),
        .err_clr    (err_clr),
        .data_q     (rx_data),
        .ready_q    (rx_ready),
        .ovr_q      (ovr_q),
        .fe_q       (fe_q)
    );

    assign status = {ext_s, rxd_s, fe_q, ovr_q, rx_ready};

endmodule

// File: tb/usart_rx_tb.sv
module usart_rx_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rxc = 1'b0;
    logic       rxd = 1'b1;
    logic       ext_sync = 1'b0;
    logic       sync_mode = 1'b0;
    logic       fac_sel = 1'b0;
    logic [1:0] len_sel = 2'd3;
    logic       rx_en = 1'b0;
    logic       rd_strobe = 1'b0;
    logic       err_clr = 1'b0;
    logic [7:0] rx_data;
    logic       rx_ready;
    logic [4:0] status;

    int total = 0;
    int bad = 0;
    int rxc_half = 2;
    bit done = 1'b0;

    usart_rx u_dut (
        .clk(clk), .rst_n(rst_n), .rxc(rxc), .rxd(rxd), .ext_sync(ext_sync),
        .sync_mode(sync_mode), .fac_sel(fac_sel), .len_sel(len_sel),
        .rx_en(rx_en), .rd_strobe(rd_strobe), .err_clr(err_clr),
        .rx_data(rx_data), .rx_ready(rx_ready), .status(status)
    );

    always #2.5 clk = ~clk;

    initial begin
        forever begin
            repeat (rxc_half) @(negedge clk);
            rxc = ~rxc;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_rd();
        @(negedge clk) rd_strobe = 1'b1;
        @(negedge clk) rd_strobe = 1'b0;
        cyc(1);
    endtask

    task automatic pulse_clr();
        @(negedge clk) err_clr = 1'b1;
        @(negedge clk) err_clr = 1'b0;
        cyc(1);
    endtask

    task automatic set_cfg(input bit sm, input bit fs, input logic [1:0] ls, input bit en);
        @(negedge clk) rx_en = 1'b0;
        cyc(4);
        sync_mode = sm; fac_sel = fs; len_sel = ls;
        cyc(2);
        rx_en = en;
        cyc(40);
    endtask

    task automatic send_async(input logic [7:0] val, input int nbits, input bit stop_ok, input int fac);
        int tk;
        tk = 2 * rxc_half;
        @(negedge clk) rxd = 1'b0;
        cyc(fac * tk);
        for (int i = 0; i < nbits; i++) begin
            rxd = val[i];
            cyc(fac * tk);
        end
        if (stop_ok) begin
            rxd = 1'b1;
            cyc(fac * tk);
        end else begin
            rxd = 1'b0;
            cyc(12 * tk);
            rxd = 1'b1;
            cyc(4 * tk);
        end
        cyc(fac * tk);
    endtask

    task automatic t_reset();
        chk("R1 ready", rx_ready, 0);
        chk("R1 flags", status[2:0], 0);
        chk("R1 data", rx_data, 0);
    endtask

    task automatic t_async16();
        set_cfg(0, 0, 2'd3, 1);
        send_async(8'hA5, 8, 1, 16);
        chk("R2 ready", rx_ready, 1);
        chk("R2 data", rx_data, 8'hA5);
        chk("R2 no flags", status[2:1], 0);
        pulse_rd();
        chk("R7 ready cleared", rx_ready, 0);
        send_async(8'h3C, 8, 1, 16);
        chk("R2 second data", rx_data, 8'h3C);
        pulse_rd();
    endtask

    task automatic t_async64();
        set_cfg(0, 1, 2'd3, 1);
        send_async(8'h96, 8, 1, 64);
        chk("R3 ready", rx_ready, 1);
        chk("R3 data", rx_data, 8'h96);
        pulse_rd();
    endtask

    task automatic t_len();
        set_cfg(0, 0, 2'd0, 1);
        send_async(8'hFB, 5, 1, 16);
        chk("R4 5-bit data", rx_data, 8'h1B);
        pulse_rd();
        set_cfg(0, 0, 2'd1, 1);
        send_async(8'hED, 6, 1, 16);
        chk("R4 6-bit data", rx_data, 8'h2D);
        chk("R4 no overrun", status[1], 0);
        pulse_rd();
    endtask

    task automatic t_glitch();
        set_cfg(0, 0, 2'd3, 1);
        @(negedge clk) rxd = 1'b0;
        cyc(5 * 2 * rxc_half);
        rxd = 1'b1;
        cyc(3 * 16 * 2 * rxc_half);
        chk("R5 glitch ignored", rx_ready, 0);
        send_async(8'h5A, 8, 1, 16);
        chk("R5 recovery data", rx_data, 8'h5A);
        chk("R5 recovery ready", rx_ready, 1);
        pulse_rd();
    endtask

    task automatic t_framing();
        set_cfg(0, 0, 2'd3, 1);
        send_async(8'hC3, 8, 0, 16);
        chk("R6 framing set", status[2], 1);
        chk("R6 data kept", rx_data, 8'hC3);
        pulse_rd();
        send_async(8'h11, 8, 1, 16);
        chk("R6 framing sticky", status[2], 1);
        chk("R6 good data", rx_data, 8'h11);
        pulse_clr();
        chk("R6 framing cleared", status[2], 0);
        pulse_rd();
    endtask

    task automatic t_overrun();
        set_cfg(0, 0, 2'd3, 1);
        send_async(8'h12, 8, 1, 16);
        chk("R8 no overrun yet", status[1], 0);
        send_async(8'h34, 8, 1, 16);
        chk("R8 overrun set", status[1], 1);
        chk("R8 newer data", rx_data, 8'h34);
        pulse_rd();
        chk("R7 ready cleared", rx_ready, 0);
        chk("R7 overrun kept", status[1], 1);
        pulse_clr();
        chk("R8 overrun cleared", status[1], 0);
    endtask

    task automatic t_disabled();
        set_cfg(0, 0, 2'd3, 0);
        send_async(8'h77, 8, 1, 16);
        chk("R10 no char", rx_ready, 0);
        chk("R10 data unchanged", rx_data, 8'h34);
        @(negedge clk) rxd = 1'b0; ext_sync = 1'b1;
        cyc(4);
        chk("R11 rxd low", status[3], 0);
        chk("R11 sync high", status[4], 1);
        rxd = 1'b1; ext_sync = 1'b0;
        cyc(4);
        chk("R11 rxd high", status[3], 1);
        chk("R11 sync low", status[4], 0);
    endtask

    task automatic t_sync();
        logic [7:0] a, b;
        a = 8'hB4; b = 8'h69;
        rxc_half = 8;
        set_cfg(1, 0, 2'd3, 1);
        for (int i = 0; i < 12; i++) begin
            @(negedge rxc);
            rxd = i[0];
        end
        cyc(4);
        chk("R9 no char before sync", rx_ready, 0);
        @(negedge rxc);
        ext_sync = 1'b1;
        rxd = a[0];
        for (int i = 1; i < 8; i++) begin
            @(negedge rxc);
            rxd = a[i];
        end
        @(negedge rxc);
        rxd = b[0];
        cyc(2);
        chk("R9 first ready", rx_ready, 1);
        chk("R9 first data", rx_data, a);
        pulse_rd();
        for (int i = 1; i < 8; i++) begin
            @(negedge rxc);
            rxd = b[i];
        end
        @(negedge rxc);
        cyc(3);
        chk("R9 second data", rx_data, b);
        chk("R9 second ready", rx_ready, 1);
        chk("R9 no overrun or framing", status[2:1], 0);
        ext_sync = 1'b0;
        rxd = 1'b1;
    endtask

    initial begin
        cyc(5);
        t_reset();
        @(negedge clk) rst_n = 1'b1;
        cyc(5);
        t_async16();
        t_async64();
        t_len();
        t_glitch();
        t_framing();
        t_overrun();
        t_disabled();
        t_sync();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule